// File: doc/BRIEF.md
# Shift-Register Clock Divider with Post-Divide Stages

This block divides a clock with counters built from linear feedback shift registers instead of binary counters. Each such counter shifts left once per clock. The new bit 0 is the XNOR of a fixed set of tapped bits. When the register holds the terminal state (value 0x01), it loads a programmable reload value and the divider output toggles. Software chooses a divide ratio N by writing the state that lies N-1 steps before the terminal state in the sequence. The output then toggles once every N clocks. No binary compare or decrement is needed.

There are two such dividers: a 6-bit reference divider and an 8-bit feedback divider. A separate post-divider has two cascaded stages. One 6-bit encoded word sets both stages, and the output toggles once every product of the two stage ratios. New settings are held in a pending register and take effect only at the next toggle, so a rewrite never shortens or stretches the period that is running.

Top module: `lfsr_pll_divider`

## Requirements
- R1: Each shift-register divider toggles its output on every reload. The spacing between two toggles is N clocks when the reload value is the state reached by walking N-1 steps backwards from the terminal state 0x01. One forward step is: shift left, and bit 0 receives the XNOR of the tapped bits.
- R2: The reference divider is 6 bits wide, with taps on bits 5 and 4. It covers ratios 1 to 64. Reload 0x3f (the all-ones state, which stepping never reaches) gives a toggle every clock. Reload 0x00 gives 2, and reload 0x01 (the terminal value itself) gives 64.
- R3: The feedback divider is 8 bits wide, with taps on bits 7, 3, 2 and 1. It covers ratios 2 to 256. Reload 0x00 gives 2, 0x80 gives 3, and 0x01 gives 256.
- R4: A write to a reload register is used first at the next reload, so the running period is not changed. A write whose clock edge is itself a reload edge is first used one reload later.
- R5: A synchronous reset drives all three outputs low and puts each shift register at its terminal state. It returns both reload registers to 0x01, which gives ratios 64 and 256, and returns the post-divider setting to 0x3f, which gives a toggle every clock.
- R6: The post-divider word holds 8 minus the first-stage ratio in bits 5:3 and 8 minus the second-stage ratio in bits 2:0, so code 0 means 8. The output toggles every p1*p2 clocks.
- R7: A write to the post-divider word takes effect at the next post-divider toggle. The period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ref_wr | input | 1 | Write strobe for the reference reload value |
| ref_val | input | 6 | Reference reload value |
| fbk_wr | input | 1 | Write strobe for the feedback reload value |
| fbk_val | input | 8 | Feedback reload value |
| post_wr | input | 1 | Write strobe for the post-divider word |
| post_val | input | 6 | Post-divider word: {8-p1, 8-p2} |
| ref_out | output | 1 | Reference divider output |
| fbk_out | output | 1 | Feedback divider output |
| post_out | output | 1 | Post-divider output |

## Verification
A register write and a terminal reload can fall on the same clock edge. The reload must then use the value stored before that edge. The bench aligns to an observed toggle of the feedback divider and counts the known ratio minus one clocks. It then raises the write strobe so that it is sampled exactly on the next reload edge. Correct behaviour is two more full periods at the old ratio and then the new one. A second case places the write one edge earlier, where the new ratio must apply after a single old period.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

   localparam int                REF_W_DEF   = 6;
   localparam int                FBK_W_DEF   = 8;
   localparam logic [5:0]        REF_TAPS_DEF = 6'h30;
   localparam logic [7:0]        FBK_TAPS_DEF = 8'h8E;
   localparam int                POST_CODE_W = 3;

   // Encoded post-divider word; the first stage code sits in the upper field.
   typedef struct packed {
      logic [POST_CODE_W-1:0] first_code;
      logic [POST_CODE_W-1:0] second_code;
   } post_cfg_t;

   // Code c selects ratio 2^W - c, so the counter limit (ratio-1) is ~c.
   function automatic logic [POST_CODE_W-1:0] code_limit(logic [POST_CODE_W-1:0] code);
      return ~code;
   endfunction

endpackage

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
   parameter int               WIDTH         = 8,
   parameter logic [WIDTH-1:0] TAPS          = 8'h8E,
   parameter logic [WIDTH-1:0] TERMINAL      = 1,
   parameter bit               LOCKUP_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_wr,
   input  logic [WIDTH-1:0] load_val,
   output logic             div_out
);

   localparam logic [WIDTH-1:0] LOCKUP = '1;

   generate
      if (WIDTH < 3 || WIDTH > 16) begin : g_bad_width
         $error("lfsr_div_core: WIDTH out of supported range");
      end
      if (TERMINAL == LOCKUP) begin : g_bad_term
         $error("lfsr_div_core: terminal state must lie on the sequence");
      end
   endgenerate

   logic [WIDTH-1:0] reload_q;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] step_val;
   logic             fresh_q;
   logic             lock_hit;
   logic             wrap;

   assign step_val = {state_q[WIDTH-2:0], ~^(state_q & TAPS)};

   generate
      if (LOCKUP_BYPASS) begin : g_bypass
         assign lock_hit = (state_q == LOCKUP);
      end else begin : g_no_bypass
         assign lock_hit = 1'b0;
      end
   endgenerate

   // The terminal compare is skipped on the cycle right after a load, so a
   // reload equal to the terminal value runs one full sequence.
   assign wrap = lock_hit || ((state_q == TERMINAL) && !fresh_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         reload_q <= TERMINAL;
      end else if (load_wr) begin
         reload_q <= load_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TERMINAL;
         fresh_q <= 1'b0;
         div_out <= 1'b0;
      end else if (wrap) begin
         state_q <= reload_q;
         fresh_q <= 1'b1;
         div_out <= ~div_out;
      end else begin
         state_q <= step_val;
         fresh_q <= 1'b0;
      end
   end

   // R1
   toggle_at_terminal_chk: assert property (@(posedge clk) disable iff (rst)
      (div_out != $past(div_out)) |-> ($past(state_q) == TERMINAL || $past(state_q) == LOCKUP));

   // R4
   reload_uses_stored_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wrap)) |-> (state_q == $past(reload_q)));

   // R2
   lockup_only_loaded_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && state_q == LOCKUP) |-> ($past(reload_q) == LOCKUP));

endmodule

// File: rtl/lfsr_post_div.sv
module lfsr_post_div
   import lfsr_div_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_wr,
   input  logic [2*POST_CODE_W-1:0] cfg_val,
   output logic                     div_out
);

   localparam post_cfg_t             CFG_RESET = '1;
   localparam logic [POST_CODE_W-1:0] ONE     = 1;

   post_cfg_t               pend_q;
   post_cfg_t               act_q;
   logic [POST_CODE_W-1:0]  cnt1_q;
   logic [POST_CODE_W-1:0]  cnt2_q;
   logic [POST_CODE_W-1:0]  lim1;
   logic [POST_CODE_W-1:0]  lim2;
   logic                    pulse1;
   logic                    last;

   assign lim1   = code_limit(act_q.first_code);
   assign lim2   = code_limit(act_q.second_code);
   assign pulse1 = (cnt1_q == lim1);
   assign last   = pulse1 && (cnt2_q == lim2);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= CFG_RESET;
      end else if (cfg_wr) begin
         pend_q <= cfg_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt1_q  <= '0;
         cnt2_q  <= '0;
         act_q   <= CFG_RESET;
         div_out <= 1'b0;
      end else if (last) begin
         cnt1_q  <= '0;
         cnt2_q  <= '0;
         act_q   <= pend_q;
         div_out <= ~div_out;
      end else if (pulse1) begin
         cnt1_q  <= '0;
         cnt2_q  <= cnt2_q + ONE;
      end else begin
         cnt1_q  <= cnt1_q + ONE;
      end
   end

   // R6
   post_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (div_out != $past(div_out)) |-> (cnt1_q == '0 && cnt2_q == '0));

   // R7
   post_adopt_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(last)) |-> (act_q == $past(pend_q)));

   // R7
   post_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(last)) |-> $stable(act_q));

endmodule

// File: rtl/lfsr_pll_divider.sv
module lfsr_pll_divider
   import lfsr_div_pkg::*;
#(
   parameter int                   REF_WIDTH = REF_W_DEF,
   parameter int                   FBK_WIDTH = FBK_W_DEF,
   parameter logic [REF_WIDTH-1:0] REF_TAPS  = REF_TAPS_DEF,
   parameter logic [FBK_WIDTH-1:0] FBK_TAPS  = FBK_TAPS_DEF
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ref_wr,
   input  logic [REF_WIDTH-1:0]     ref_val,
   input  logic                     fbk_wr,
   input  logic [FBK_WIDTH-1:0]     fbk_val,
   input  logic                     post_wr,
   input  logic [2*POST_CODE_W-1:0] post_val,
   output logic                     ref_out,
   output logic                     fbk_out,
   output logic                     post_out
);

   localparam logic [REF_WIDTH-1:0] REF_TERM = 1;
   localparam logic [FBK_WIDTH-1:0] FBK_TERM = 1;

   generate
      if (FBK_WIDTH < REF_WIDTH) begin : g_bad_order
         $error("lfsr_pll_divider: feedback divider narrower than reference");
      end
   endgenerate

   lfsr_div_core #(
      .WIDTH         (REF_WIDTH),
      .TAPS          (REF_TAPS),
      .TERMINAL      (REF_TERM),
      .LOCKUP_BYPASS (1'b1)
   ) i_ref_div (
      .clk      (clk),
      .rst      (rst),
      .load_wr  (ref_wr),
      .load_val (ref_val),
      .div_out  (ref_out)
   );

   lfsr_div_core #(
      .WIDTH         (FBK_WIDTH),
      .TAPS          (FBK_TAPS),
      .TERMINAL      (FBK_TERM),
      .LOCKUP_BYPASS (1'b0)
   ) i_fbk_div (
      .clk      (clk),
      .rst      (rst),
      .load_wr  (fbk_wr),
      .load_val (fbk_val),
      .div_out  (fbk_out)
   );

   lfsr_post_div i_post_div (
      .clk     (clk),
      .rst     (rst),
      .cfg_wr  (post_wr),
      .cfg_val (post_val),
      .div_out (post_out)
   );

endmodule

// File: tb/test_lfsr_pll_divider.sv
`timescale 1ns/1ps
module test_lfsr_pll_divider;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_wr = 1'b0;
   logic [5:0] ref_val = '0;
   logic       fbk_wr = 1'b0;
   logic [7:0] fbk_val = '0;
   logic       post_wr = 1'b0;
   logic [5:0] post_val = '0;
   logic       ref_out, fbk_out, post_out;
   logic [2:0] outs;

   int n_chk = 0;
   int n_bad = 0;
   int tog [3];
   int gap [3];
   int cnt [3];
   logic prv [3];

   always #4 clk = ~clk;

   lfsr_pll_divider i_lfsr_pll_divider (
      .clk(clk), .rst(rst),
      .ref_wr(ref_wr), .ref_val(ref_val),
      .fbk_wr(fbk_wr), .fbk_val(fbk_val),
      .post_wr(post_wr), .post_val(post_val),
      .ref_out(ref_out), .fbk_out(fbk_out), .post_out(post_out)
   );

   assign outs = {post_out, fbk_out, ref_out};

   initial begin
      for (int k = 0; k < 3; k++) begin
         tog[k] = 0; gap[k] = 0; cnt[k] = 0; prv[k] = 1'b0;
      end
   end

   // Toggle monitor, sampled 2 ns after each rising edge.
   always @(posedge clk) begin
      #2;
      for (int k = 0; k < 3; k++) begin
         if (rst) begin
            cnt[k] = 0;
            prv[k] = outs[k];
         end else begin
            cnt[k] = cnt[k] + 1;
            if (outs[k] != prv[k]) begin
               gap[k] = cnt[k];
               cnt[k] = 0;
               tog[k] = tog[k] + 1;
               prv[k] = outs[k];
            end
         end
      end
   end

   // Tap masks and terminal state are taken from R2/R3.
   localparam int REF_TAP = 'h30;
   localparam int FBK_TAP = 'h8E;

   function automatic int lf_next(int s, int w, int taps);
      int fb;
      fb = (^(s & taps)) ? 0 : 1;
      return ((s << 1) | fb) & ((1 << w) - 1);
   endfunction

   function automatic int lf_prev(int s, int w, int taps);
      for (int b = 0; b < 2; b++) begin
         int p;
         p = (s >> 1) | (b << (w - 1));
         if (lf_next(p, w, taps) == s) return p;
      end
      return -1;
   endfunction

   function automatic int reload_for(int ratio, int w, int taps);
      int s;
      if (ratio == 1) return (1 << w) - 1;
      s = 1;
      for (int i = 0; i < ratio - 1; i++) s = lf_prev(s, w, taps);
      return s;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic prog(int sel, int val, output int c0);
      @(negedge clk);
      c0 = tog[sel];
      case (sel)
         0: begin ref_wr = 1'b1; ref_val = 6'(val); end
         1: begin fbk_wr = 1'b1; fbk_val = 8'(val); end
         default: begin post_wr = 1'b1; post_val = 6'(val); end
      endcase
      @(negedge clk);
      ref_wr = 1'b0; fbk_wr = 1'b0; post_wr = 1'b0;
   endtask

   task automatic wait_tog(int sel, int target);
      while (tog[sel] < target) @(negedge clk);
   endtask

   task automatic settle(int sel, int val, int exp, string req);
      int c0;
      prog(sel, val, c0);
      wait_tog(sel, c0 + 3);
      chk(req, gap[sel], exp);
   endtask

   function automatic int post_word(int p1, int p2);
      return ((8 - p1) << 3) | (8 - p2);
   endfunction

   // Columns: divider select (0 ref, 1 feedback, 2 post), ratio a, ratio b.
   localparam int NV = 17;
   localparam int VEC [NV][3] = '{
      '{0, 1, 0}, '{0, 2, 0}, '{0, 3, 0}, '{0, 7, 0}, '{0, 33, 0}, '{0, 63, 0}, '{0, 64, 0},
      '{1, 2, 0}, '{1, 3, 0}, '{1, 17, 0}, '{1, 100, 0}, '{1, 255, 0}, '{1, 256, 0},
      '{2, 1, 1}, '{2, 8, 8}, '{2, 5, 3}, '{2, 4, 1}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(8ns * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int c;
      int c0;
      // R5: outputs low while reset is held
      repeat (3) @(negedge clk);
      chk("R5 ref_out in reset", int'(ref_out), 0);
      chk("R5 fbk_out in reset", int'(fbk_out), 0);
      chk("R5 post_out in reset", int'(post_out), 0);
      rst = 1'b0;
      // R5: default ratios after reset
      c = tog[0]; wait_tog(0, c + 2); chk("R5 ref default ratio", gap[0], 64);
      c = tog[2]; wait_tog(2, c + 2); chk("R5 post default ratio", gap[2], 1);
      c = tog[1]; wait_tog(1, c + 2); chk("R5 fbk default ratio", gap[1], 256);

      // Reference model against the stated reload values (R2, R3)
      chk("R3 model ratio 2", reload_for(2, 8, FBK_TAP), 'h00);
      chk("R3 model ratio 3", reload_for(3, 8, FBK_TAP), 'h80);
      chk("R2 model ratio 2", reload_for(2, 6, REF_TAP), 'h00);

      // Vector table: R1 for the shift-register dividers, R6 for the post-divider
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][0] == 0)
            settle(0, reload_for(VEC[v][1], 6, REF_TAP), VEC[v][1], "R1 ref ratio");
         else if (VEC[v][0] == 1)
            settle(1, reload_for(VEC[v][1], 8, FBK_TAP), VEC[v][1], "R1 fbk ratio");
         else
            settle(2, post_word(VEC[v][1], VEC[v][2]), VEC[v][1] * VEC[v][2], "R6 post ratio");
      end

      // Literal reload values
      settle(0, 'h3f, 1, "R2 ref 0x3f");
      settle(0, 'h00, 2, "R2 ref 0x00");
      settle(0, 'h01, 64, "R2 ref 0x01");
      settle(1, 'h00, 2, "R3 fbk 0x00");
      settle(1, 'h80, 3, "R3 fbk 0x80");
      settle(1, 'h01, 256, "R3 fbk 0x01");

      // R4: write sampled exactly on a reload edge (old ratio 5 -> new 9)
      settle(1, reload_for(5, 8, FBK_TAP), 5, "R4 setup");
      c = tog[1]; wait_tog(1, c + 1); c = tog[1];
      repeat (4) @(negedge clk);
      fbk_wr = 1'b1; fbk_val = 8'(reload_for(9, 8, FBK_TAP));
      @(negedge clk); fbk_wr = 1'b0;
      wait_tog(1, c + 1); chk("R4 period in progress", gap[1], 5);
      wait_tog(1, c + 2); chk("R4 write on reload edge keeps old", gap[1], 5);
      wait_tog(1, c + 3); chk("R4 new ratio after next reload", gap[1], 9);

      // R4: write one edge before the reload (old 9 -> new 4)
      c = tog[1]; wait_tog(1, c + 1); c = tog[1];
      repeat (7) @(negedge clk);
      fbk_wr = 1'b1; fbk_val = 8'(reload_for(4, 8, FBK_TAP));
      @(negedge clk); fbk_wr = 1'b0;
      wait_tog(1, c + 1); chk("R4 early write keeps running period", gap[1], 9);
      wait_tog(1, c + 2); chk("R4 early write applied", gap[1], 4);

      // R7: post rewrite mid-period (3x2 -> 2x2)
      settle(2, post_word(3, 2), 6, "R7 setup");
      c = tog[2]; wait_tog(2, c + 1); c = tog[2];
      prog(2, post_word(2, 2), c0);
      wait_tog(2, c + 1); chk("R7 old post period completes", gap[2], 6);
      wait_tog(2, c + 2); chk("R7 new post ratio", gap[2], 4);

      // R5: reset in mid-run
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 ref_out mid-run reset", int'(ref_out), 0);
      chk("R5 fbk_out mid-run reset", int'(fbk_out), 0);
      chk("R5 post_out mid-run reset", int'(post_out), 0);
      rst = 1'b0;
      c = tog[0]; wait_tog(0, c + 2); chk("R5 ref ratio restored", gap[0], 64);

      summary();
      $finish;
   end

endmodule